// File: doc/BRIEF.md
# Translation Cache with Range Purge

A small, fully associative cache of virtual-to-physical page translations. Every entry carries a 3-bit region tag, a page base aligned to its own page size (a power of two between 4 KiB and 256 MiB) and a physical page number. A lookup port gives a combinational hit, the index of the hit entry and its physical page number. An insert port writes a new translation into the lowest-numbered free entry. When no entry is free, it overwrites the entry that a rotating pointer selects.

A purge request carries a 64-bit address word and a size word. Every entry in the same region whose page overlaps the purged range, in part or in full, is invalidated in the clock edge that accepts the request. All entries are compared in parallel, and a one-cycle completion pulse follows. Only a requester at the most privileged level with the virtualization flag clear is served. Any other request raises a one-cycle fault pulse and changes nothing.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `pg_done` and `pg_fault` are low.
- R2: An insert with a page-size exponent in 12..28 writes the lowest-numbered invalid entry on the next clock edge. The stored base is the insert address with its low `ins_ps` bits cleared. From then on, any lookup address inside that page returns a hit with the stored physical page number and the entry index on `lk_idx`. When several entries match, the lowest index wins.
- R3: An insert whose page-size exponent is below 12 or above 28 changes no entry and consumes no free slot.
- R4: When all 16 entries are valid, an insert overwrites the entry at a rotating pointer. The pointer starts at 0 after reset, advances by one only on such a full-cache insert, and wraps from 15 to 0.
- R5: A lookup hits only when the region tag matches. It is purely combinational from the current entry state.
- R6: The purge address is `pg_addr[60:0]` and the purge region is `pg_addr[63:61]`. The purge range is 2^`pg_size[7:2]` bytes, aligned down to that size. All other bits of `pg_size` are ignored.
- R7: An accepted purge invalidates every entry of the purge region whose page overlaps the purge range. This covers a small range inside a large page and a large range covering small pages. A range of 2^61 bytes or more clears the whole region.
- R8: Entries of another region, and entries whose pages do not overlap the purge range, stay valid.
- R9: A purge is accepted only when `pg_priv` is 0 and `pg_vm` is 0. Otherwise `pg_fault` pulses for one cycle after the request edge, `pg_done` stays low and no entry changes.
- R10: `pg_done` goes high for exactly one cycle, in the cycle after the edge that accepted the purge.
- R11: A lookup in the same cycle as a purge request returns the state from before the purge.
- R12: An insert in the same cycle as an accepted purge still takes effect, even when the purge range covers the inserted page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Insert strobe |
| ins_rgn | input | 3 | Region tag of the new entry |
| ins_va | input | 61 | Virtual address inside the new page |
| ins_ps | input | 5 | Page-size exponent of the new entry |
| ins_ppn | input | 28 | Physical page number of the new entry |
| lk_rgn | input | 3 | Lookup region tag |
| lk_va | input | 61 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Index of the hit entry |
| lk_ppn | output | 28 | Physical page number of the hit entry |
| pg_req | input | 1 | Purge request strobe |
| pg_addr | input | 64 | Purge address word: region in [63:61], address in [60:0] |
| pg_size | input | 64 | Purge size word, exponent in [7:2] |
| pg_priv | input | 2 | Requester privilege level, 0 is most privileged |
| pg_vm | input | 1 | Virtualization mode flag |
| pg_done | output | 1 | Purge completion pulse |
| pg_fault | output | 1 | Rejected purge pulse |

## Verification
Two pairs of functions can fall in the same cycle: a lookup with a purge, and an insert with a purge. For the first pair, the bench holds a lookup on a page while it raises a purge request that covers that page. The lookup must still hit with the old physical page number in that cycle and miss one cycle later. For the second pair, the bench strobes an insert and an overlapping purge in the same cycle. The new page must hit afterwards, and the old overlapping entries must miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int ADDR_W    = 64;
   localparam int RGN_W     = 3;
   localparam int VA_W      = ADDR_W - RGN_W;
   localparam int PS_W      = 5;
   localparam int PEXP_LSB  = 2;
   localparam int PEXP_MSB  = 7;
   localparam int PEXP_W    = PEXP_MSB - PEXP_LSB + 1;

   // keep bits at or above exponent e; an exponent past the address width keeps none
   function automatic logic [VA_W-1:0] xc_mask(input logic [PEXP_W-1:0] e);
      logic [VA_W-1:0] m;
      if (int'(e) >= VA_W) m = '0;
      else                 m = {VA_W{1'b1}} << e;
      return m;
   endfunction

   function automatic logic [PEXP_W-1:0] xc_ext(input logic [PS_W-1:0] ps);
      return {{(PEXP_W-PS_W){1'b0}}, ps};
   endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
   import xlat_pkg::*;
#(
   parameter int PPN_W = 28
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [RGN_W-1:0]  wr_rgn,
   input  logic [VA_W-1:0]   wr_va,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic              purge_en,
   input  logic [RGN_W-1:0]  pg_rgn,
   input  logic [VA_W-1:0]   pg_va,
   input  logic [PEXP_W-1:0] pg_exp,
   input  logic [RGN_W-1:0]  lk_rgn,
   input  logic [VA_W-1:0]   lk_va,
   output logic              valid,
   output logic              lk_match,
   output logic              pg_ovl,
   output logic [PPN_W-1:0]  ppn
);

   logic [RGN_W-1:0]  rgn_q;
   logic [VA_W-1:0]   base_q;
   logic [PS_W-1:0]   ps_q;
   logic [PPN_W-1:0]  ppn_q;
   logic              valid_q;
   logic [PEXP_W-1:0] span_exp;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         rgn_q   <= '0;
         base_q  <= '0;
         ps_q    <= '0;
         ppn_q   <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         rgn_q   <= wr_rgn;
         base_q  <= wr_va & xc_mask(xc_ext(wr_ps));
         ps_q    <= wr_ps;
         ppn_q   <= wr_ppn;
      end else if (purge_en && pg_ovl) begin
         valid_q <= 1'b0;
      end
   end

   // the larger of the two sizes decides the alignment for the overlap test
   always_comb begin
      span_exp = (xc_ext(ps_q) > pg_exp) ? xc_ext(ps_q) : pg_exp;
      pg_ovl   = (rgn_q == pg_rgn) &&
                 (((pg_va ^ base_q) & xc_mask(span_exp)) == '0);
      lk_match = valid_q && (rgn_q == lk_rgn) &&
                 (((lk_va ^ base_q) & xc_mask(xc_ext(ps_q))) == '0);
   end

   assign valid = valid_q;
   assign ppn   = ppn_q;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N_ENTRIES = 16,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [N_ENTRIES-1:0] valid,
   input  logic                 adv,
   output logic [N_ENTRIES-1:0] sel
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      sel = '0;
      sel[any_free ? free_idx : ptr_q] = 1'b1;
   end

   generate
      if ((1 << IDX_W) == N_ENTRIES) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst)                  ptr_q <= '0;
            else if (adv && !any_free) ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst) ptr_q <= '0;
            else if (adv && !any_free)
               ptr_q <= (ptr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int PPN_W     = 28,
   parameter int PS_MIN    = 12,
   parameter int PS_MAX    = 28,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ins_valid,
   input  logic [RGN_W-1:0]  ins_rgn,
   input  logic [VA_W-1:0]   ins_va,
   input  logic [PS_W-1:0]   ins_ps,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [RGN_W-1:0]  lk_rgn,
   input  logic [VA_W-1:0]   lk_va,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [PPN_W-1:0]  lk_ppn,
   input  logic              pg_req,
   input  logic [ADDR_W-1:0] pg_addr,
   input  logic [ADDR_W-1:0] pg_size,
   input  logic [1:0]        pg_priv,
   input  logic              pg_vm,
   output logic              pg_done,
   output logic              pg_fault
);

   generate
      if (N_ENTRIES < 2 || PS_MIN < 1 || PS_MIN > PS_MAX ||
          PS_MAX >= VA_W || PS_MAX >= (1 << PS_W)) begin : g_bad_cfg
         $error("xlat_cache: illegal parameter set");
      end
   endgenerate

   logic                 ins_ok;
   logic                 pg_ok;
   logic [RGN_W-1:0]     pg_rgn;
   logic [VA_W-1:0]      pg_va;
   logic [PEXP_W-1:0]    pg_exp;
   logic [N_ENTRIES-1:0] ent_valid;
   logic [N_ENTRIES-1:0] ent_match;
   logic [N_ENTRIES-1:0] ent_ovl;
   logic [N_ENTRIES-1:0] ent_sel;
   logic [PPN_W-1:0]     ent_ppn [N_ENTRIES];
   logic                 done_q;
   logic                 fault_q;
   logic                 unused_size;

   assign ins_ok = ins_valid && (int'(ins_ps) >= PS_MIN) && (int'(ins_ps) <= PS_MAX);
   assign pg_ok  = pg_req && (pg_priv == 2'd0) && !pg_vm;
   assign pg_rgn = pg_addr[ADDR_W-1:VA_W];
   assign pg_va  = pg_addr[VA_W-1:0];
   assign pg_exp = pg_size[PEXP_MSB:PEXP_LSB];
   assign unused_size = ^{pg_size[ADDR_W-1:PEXP_MSB+1], pg_size[PEXP_LSB-1:0]};

   xlat_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
      .clk   (clk),
      .rst   (rst),
      .valid (ent_valid),
      .adv   (ins_ok),
      .sel   (ent_sel)
   );

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      xlat_entry #(.PPN_W(PPN_W)) u_ent (
         .clk      (clk),
         .rst      (rst),
         .wr_en    (ins_ok && ent_sel[g]),
         .wr_rgn   (ins_rgn),
         .wr_va    (ins_va),
         .wr_ps    (ins_ps),
         .wr_ppn   (ins_ppn),
         .purge_en (pg_ok),
         .pg_rgn   (pg_rgn),
         .pg_va    (pg_va),
         .pg_exp   (pg_exp),
         .lk_rgn   (lk_rgn),
         .lk_va    (lk_va),
         .valid    (ent_valid[g]),
         .lk_match (ent_match[g]),
         .pg_ovl   (ent_ovl[g]),
         .ppn      (ent_ppn[g])
      );
   end

   always_comb begin
      lk_hit = 1'b0;
      lk_idx = '0;
      lk_ppn = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (ent_match[i]) begin
            lk_hit = 1'b1;
            lk_idx = IDX_W'(i);
            lk_ppn = ent_ppn[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= pg_ok;
         fault_q <= pg_req && !pg_ok;
      end
   end

   assign pg_done  = done_q;
   assign pg_fault = fault_q;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int N_ENTRIES = 16,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 pg_req,
   input logic [1:0]           pg_priv,
   input logic                 pg_vm,
   input logic                 ins_valid,
   input logic                 pg_done,
   input logic                 pg_fault,
   input logic                 lk_hit,
   input logic [IDX_W-1:0]     lk_idx,
   input logic [N_ENTRIES-1:0] ent_valid,
   input logic [N_ENTRIES-1:0] ent_ovl
);

   logic rst_d;
   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst_d && !rst) begin
         // R1: reset leaves no valid entry and no pulses
         a_clean_after_reset_r1: assert (ent_valid == '0 && !pg_done && !pg_fault);
      end
   end

   p_done_source_r10: assert property (@(posedge clk) disable iff (rst)
      pg_done |-> $past(pg_req && pg_priv == 2'd0 && !pg_vm));

   p_fault_source_r9: assert property (@(posedge clk) disable iff (rst)
      pg_fault |-> $past(pg_req && (pg_priv != 2'd0 || pg_vm)));

   p_done_fault_excl_r9: assert property (@(posedge clk) disable iff (rst)
      !(pg_done && pg_fault));

   p_fault_no_change_r9: assert property (@(posedge clk) disable iff (rst)
      (pg_fault && !$past(ins_valid)) |-> ent_valid == $past(ent_valid));

   p_purge_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (pg_done && !$past(ins_valid)) |-> (ent_valid & $past(ent_ovl)) == '0);

   p_hit_is_valid_r2: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> ent_valid[lk_idx]);

endmodule

bind xlat_cache xlat_cache_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .pg_req    (pg_req),
   .pg_priv   (pg_priv),
   .pg_vm     (pg_vm),
   .ins_valid (ins_valid),
   .pg_done   (pg_done),
   .pg_fault  (pg_fault),
   .lk_hit    (lk_hit),
   .lk_idx    (lk_idx),
   .ent_valid (ent_valid),
   .ent_ovl   (ent_ovl)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

   logic        clk = 1'b0;
   logic        rst;
   logic        ins_valid;
   logic [2:0]  ins_rgn;
   logic [60:0] ins_va;
   logic [4:0]  ins_ps;
   logic [27:0] ins_ppn;
   logic [2:0]  lk_rgn;
   logic [60:0] lk_va;
   logic        lk_hit;
   logic [3:0]  lk_idx;
   logic [27:0] lk_ppn;
   logic        pg_req;
   logic [63:0] pg_addr;
   logic [63:0] pg_size;
   logic [1:0]  pg_priv;
   logic        pg_vm;
   logic        pg_done;
   logic        pg_fault;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  finished = 0;

   always #5 clk = ~clk;

   xlat_cache i_xlat_cache (
      .clk(clk), .rst(rst),
      .ins_valid(ins_valid), .ins_rgn(ins_rgn), .ins_va(ins_va),
      .ins_ps(ins_ps), .ins_ppn(ins_ppn),
      .lk_rgn(lk_rgn), .lk_va(lk_va),
      .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
      .pg_req(pg_req), .pg_addr(pg_addr), .pg_size(pg_size),
      .pg_priv(pg_priv), .pg_vm(pg_vm),
      .pg_done(pg_done), .pg_fault(pg_fault)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; ins_valid = 0; ins_rgn = 0; ins_va = 0; ins_ps = 0; ins_ppn = 0;
      lk_rgn = 0; lk_va = 0; pg_req = 0; pg_addr = 0; pg_size = 0; pg_priv = 0; pg_vm = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_insert(input logic [2:0] r, input logic [60:0] va, input logic [4:0] ps, input logic [27:0] ppn);
      @(negedge clk);
      ins_valid = 1; ins_rgn = r; ins_va = va; ins_ps = ps; ins_ppn = ppn;
      @(negedge clk);
      ins_valid = 0;
   endtask

   task automatic look(input logic [2:0] r, input logic [60:0] va, input bit exp_hit,
                       input logic [27:0] exp_ppn, input string tag);
      lk_rgn = r; lk_va = va;
      #1;
      chk(lk_hit == exp_hit, {tag, " hit"}, 64'(lk_hit), 64'(exp_hit));
      if (exp_hit) chk(lk_ppn == exp_ppn, {tag, " ppn"}, 64'(lk_ppn), 64'(exp_ppn));
   endtask

   task automatic look_idx(input logic [2:0] r, input logic [60:0] va, input logic [3:0] exp_idx, input string tag);
      lk_rgn = r; lk_va = va;
      #1;
      chk(lk_hit && lk_idx == exp_idx, tag, {59'(lk_hit), 1'b0, lk_idx}, {59'(1), 1'b0, exp_idx});
   endtask

   task automatic do_purge(input logic [2:0] r, input logic [60:0] va, input logic [63:0] size_word,
                           input logic [1:0] priv, input bit vm, input bit expect_ok, input string tag);
      @(negedge clk);
      pg_req = 1; pg_addr = {r, va}; pg_size = size_word; pg_priv = priv; pg_vm = vm;
      @(negedge clk);
      pg_req = 0;
      #1;
      chk(pg_done == expect_ok, {tag, " done pulse R10"}, 64'(pg_done), 64'(expect_ok));
      chk(pg_fault == !expect_ok, {tag, " fault pulse R9"}, 64'(pg_fault), 64'(!expect_ok));
      @(negedge clk);
      #1;
      chk(!pg_done && !pg_fault, {tag, " pulse width R10"}, {pg_done, pg_fault}, 64'(0));
   endtask

   function automatic logic [63:0] szw(input int e);
      return 64'(e) << 2;
   endfunction

   task automatic t_reset();
      do_reset();
      look(0, 61'h0, 0, 0, "R1 miss at 0");
      look(3, 61'h1234_5000, 0, 0, "R1 miss rgn3");
      chk(!pg_done && !pg_fault, "R1 pulses low", {pg_done, pg_fault}, 64'(0));
   endtask

   task automatic t_insert();
      do_reset();
      do_insert(1, 61'h1234_5000, 12, 28'hABC);
      look(1, 61'h1234_5FFF, 1, 28'hABC, "R2 inside 4K page");
      look(1, 61'h1234_6000, 0, 0, "R2 past 4K page");
      look(2, 61'h1234_5000, 0, 0, "R5 region mismatch");
      do_insert(1, 61'h4_0123, 16, 28'h55);
      look_idx(1, 61'h4_FFFF, 1, "R2 aligned 64K base, idx 1");
      look(1, 61'h4_0000, 1, 28'h55, "R2 64K base hit");
   endtask

   task automatic t_bad_ps();
      do_reset();
      do_insert(0, 61'h8000, 11, 28'h11);
      do_insert(0, 61'h9000, 29, 28'h22);
      look(0, 61'h8000, 0, 0, "R3 ps 11 ignored");
      look(0, 61'h0, 0, 0, "R3 ps 29 ignored");
      do_insert(0, 61'hA000, 12, 28'h33);
      look_idx(0, 61'hA000, 0, "R3 no slot consumed");
   endtask

   task automatic t_overlap();
      do_reset();
      do_insert(0, 61'h20_0000, 21, 28'h1);   // 2M page
      do_insert(0, 61'h60_0000, 12, 28'h2);   // 4K page
      do_insert(0, 61'h80_0000, 12, 28'h3);   // 4K page outside
      do_insert(1, 61'h20_0000, 21, 28'h4);   // other region
      // 4K purge inside the 2M page; junk in size bits outside [7:2] (R6)
      do_purge(0, 61'h2A_BC00, 64'hFFFF_FF00 | szw(12) | 64'h3, 0, 0, 1, "R6 small purge");
      look(0, 61'h20_0000, 0, 0, "R7 small range inside big page");
      look(0, 61'h60_0000, 1, 28'h2, "R8 far page kept");
      // 4M purge at 0x400000 covers the 4K page at 0x600000
      do_purge(0, 61'h40_0000, szw(22), 0, 0, 1, "R7 big purge");
      look(0, 61'h60_0000, 0, 0, "R7 big range covers small page");
      look(0, 61'h80_0000, 1, 28'h3, "R8 adjacent page kept");
      look(1, 61'h20_0000, 1, 28'h4, "R8 other region kept");
      do_purge(1, 61'h0, szw(63), 0, 0, 1, "R7 region flush");
      look(1, 61'h20_0000, 0, 0, "R7 whole region cleared");
      look(0, 61'h80_0000, 1, 28'h3, "R8 other region survives flush");
   endtask

   task automatic t_fault();
      do_reset();
      do_insert(2, 61'h3000, 12, 28'h9);
      do_purge(2, 61'h3000, szw(12), 3, 0, 0, "R9 low privilege");
      look(2, 61'h3000, 1, 28'h9, "R9 entry kept after priv fault");
      do_purge(2, 61'h3000, szw(12), 0, 1, 0, "R9 vm set");
      look(2, 61'h3000, 1, 28'h9, "R9 entry kept after vm fault");
   endtask

   task automatic t_rotate();
      do_reset();
      for (int i = 0; i < 16; i++) do_insert(0, 61'(i) << 12, 12, 28'(i));
      look_idx(0, 61'h5000, 5, "R2 fill order idx 5");
      do_insert(0, 61'h10_0000, 12, 28'h77);
      look_idx(0, 61'h10_0000, 0, "R4 first replacement idx 0");
      look(0, 61'h0, 0, 0, "R4 old entry 0 gone");
      do_insert(0, 61'h10_1000, 12, 28'h78);
      look_idx(0, 61'h10_1000, 1, "R4 second replacement idx 1");
      do_purge(0, 61'h5000, szw(12), 0, 0, 1, "R4 free one");
      do_insert(0, 61'h10_2000, 12, 28'h79);
      look_idx(0, 61'h10_2000, 5, "R2 free slot before pointer");
      do_insert(0, 61'h10_3000, 12, 28'h7A);
      look_idx(0, 61'h10_3000, 2, "R4 pointer held while free slot used");
   endtask

   task automatic t_same_cycle();
      do_reset();
      do_insert(4, 61'h7000, 12, 28'hC1);
      @(negedge clk);
      pg_req = 1; pg_addr = {3'd4, 61'h7000}; pg_size = szw(12); pg_priv = 0; pg_vm = 0;
      look(4, 61'h7000, 1, 28'hC1, "R11 lookup sees old state");
      @(negedge clk);
      pg_req = 0;
      look(4, 61'h7000, 0, 0, "R11 purged next cycle");
      // insert together with a purge covering the new page
      do_insert(4, 61'h9000, 12, 28'hD1);
      @(negedge clk);
      ins_valid = 1; ins_rgn = 4; ins_va = 61'h8000; ins_ps = 12; ins_ppn = 28'hD2;
      pg_req = 1; pg_addr = {3'd4, 61'h0}; pg_size = szw(16); pg_priv = 0; pg_vm = 0;
      @(negedge clk);
      ins_valid = 0; pg_req = 0;
      look(4, 61'h8000, 1, 28'hD2, "R12 insert survives purge");
      look(4, 61'h9000, 0, 0, "R12 older entry purged");
   endtask

   initial begin
      t_reset();
      t_insert();
      t_bad_ps();
      t_overlap();
      t_fault();
      t_rotate();
      t_same_cycle();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(10ns * 150000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule